// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block gathers up to sixteen hardware event lines into a bank of sticky status bits. A matching bank of enable bits selects which of those bits may raise the system control interrupt (SCI). Software reaches both banks through a small I/O window at a fixed base address. It reads pending events, acknowledges them by writing ones, and programs the enables. The SCI output is a level that stays high while any enabled status bit is pending and the power-management control register has interrupts switched on.

The host side takes one access per cycle of 1 to 4 bytes, starting at any address. The access is split into byte lanes, with lane k at address `addr+k` (little-endian). Each lane that lands inside the four-byte window is applied to the register byte it hits, and lanes that land outside are dropped. All lanes of one access take effect together. Read data comes back one cycle later.

Top module: `gpe_event_block`

## Requirements
- R1: Only addresses BASE_ADDR to BASE_ADDR+3 (default 0xAFE0 to 0xAFE3) reach the registers. Write lanes outside this range change nothing, and read lanes outside it return 0x00.
- R2: An access of size N (1 to 4) covers addresses `acc_addr` to `acc_addr+N-1`. Lane k uses bits [8k+7:8k] of `acc_wdata` and of `rd_data`. An access that only partly overlaps the window acts on its overlapping lanes alone.
- R3: A rising edge on `evt_in[k]` sets status bit k whatever the enable bit holds. A line that stays high does not set the bit again after it is cleared.
- R4: Window offset 0 holds status bits 7:0 and offset 1 holds status bits 15:8. Offset 2 holds enable bits 7:0 and offset 3 holds enable bits 15:8. Bit k of each bank sits at bit k%8 of its byte.
- R5: Writing a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged. A rising event in the same cycle as the clear of its bit leaves the bit set.
- R6: Writing an enable byte replaces that byte. Without a write to the window the enable bank holds its value.
- R7: A read returns `rd_valid`=1 and `rd_data` in the cycle after it is presented. The data shows the register values from before that cycle's updates, and lanes at or beyond the access size read 0x00.
- R8: `sci` is registered. It is high exactly when `sci_en` was high and (status AND enable) was nonzero after the same clock edge, so a write or event changes `sci` in the same cycle as the registers.
- R9: Synchronous reset clears status, enable, `sci` and `rd_valid`. An event line already high in the first cycle after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | I/O address of lane 0 |
| acc_size | input | 3 | Access size in bytes, 1 to 4 |
| acc_wdata | input | 32 | Write data, lane k in bits [8k+7:8k] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, lane k in bits [8k+7:8k] |
| evt_in | input | 16 | Hardware event lines |
| sci_en | input | 1 | Interrupt enable from the power-management control register |
| sci | output | 1 | System control interrupt level |

## Verification
The bench builds the block with its default parameters: a 16-bit address, base 0xAFE0, 16-bit banks and four host lanes. With these values one 4-byte access spans the whole window. Accesses starting at 0xAFDE, 0xAFDF and 0xAFE3 put lanes on both sides of the window edges, so dropped lanes on reads and writes can be observed. The bench also drives an event edge in the same cycle as the clear of its bit, and holds an event line high across reset.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int unsigned clog2_min1(input int unsigned n);
    int unsigned r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/gpe_edge_detect.sv
module gpe_edge_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] evt_q;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_in;
  end

  assign rise = evt_in & ~evt_q;
endmodule

// File: rtl/gpe_byte_lanes.sv
module gpe_byte_lanes
  import gpe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LANES     = 4,
  parameter int unsigned WIN_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'hAFE0,
  parameter int unsigned SIZE_W    = 3
) (
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [SIZE_W-1:0]         acc_size,
  input  logic [LANES*BYTE_W-1:0]   acc_wdata,
  input  logic [WIN_BYTES*BYTE_W-1:0] reg_view,
  output logic [WIN_BYTES-1:0]      wr_stb,
  output logic [WIN_BYTES*BYTE_W-1:0] wr_byte,
  output logic [LANES*BYTE_W-1:0]   rd_word
);
  localparam int unsigned OFF_W = clog2_min1(WIN_BYTES);

  logic [LANES-1:0]            lane_hit;
  logic [LANES-1:0][OFF_W-1:0] lane_off;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [ADDR_W-1:0] rel;
    assign lane_addr   = acc_addr + ADDR_W'(l);
    assign rel         = lane_addr - BASE;
    assign lane_hit[l] = acc_valid && (SIZE_W'(l) < acc_size) &&
                         (rel < ADDR_W'(WIN_BYTES));
    assign lane_off[l] = rel[OFF_W-1:0];
    assign rd_word[l*BYTE_W +: BYTE_W] =
      lane_hit[l] ? reg_view[lane_off[l]*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    wr_stb  = '0;
    wr_byte = '0;
    for (int r = 0; r < WIN_BYTES; r++) begin
      for (int l = 0; l < LANES; l++) begin
        if (acc_write && lane_hit[l] && (lane_off[l] == OFF_W'(r))) begin
          wr_stb[r] = 1'b1;
          wr_byte[r*BYTE_W +: BYTE_W] = acc_wdata[l*BYTE_W +: BYTE_W];
        end
      end
    end
  end
endmodule

// File: rtl/gpe_reg_bank.sv
module gpe_reg_bank
  import gpe_pkg::*;
#(
  parameter int unsigned BANK_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BANK_W-1:0]       rise,
  input  logic [2*BANK_W/8-1:0]   wr_stb,
  input  logic [2*BANK_W-1:0]     wr_byte,
  input  logic                    sci_en,
  output logic [BANK_W-1:0]       status_q,
  output logic [BANK_W-1:0]       enable_q,
  output logic                    sci
);
  localparam int unsigned BANK_BYTES = BANK_W / BYTE_W;

  logic [BANK_W-1:0] clr_mask;
  logic [BANK_W-1:0] status_d;
  logic [BANK_W-1:0] enable_d;

  always_comb begin
    clr_mask = '0;
    enable_d = enable_q;
    for (int b = 0; b < BANK_BYTES; b++) begin
      if (wr_stb[b])
        clr_mask[b*BYTE_W +: BYTE_W] = wr_byte[b*BYTE_W +: BYTE_W];
      if (wr_stb[BANK_BYTES+b])
        enable_d[b*BYTE_W +: BYTE_W] = wr_byte[(BANK_BYTES+b)*BYTE_W +: BYTE_W];
    end
    status_d = (status_q & ~clr_mask) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      sci      <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      sci      <= sci_en && (|(status_d & enable_d));
    end
  end
endmodule

// File: rtl/gpe_event_block.sv
module gpe_event_block
  import gpe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAFE0,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned HOST_BYTES = 4,
  parameter int unsigned SIZE_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic [SIZE_W-1:0]            acc_size,
  input  logic [HOST_BYTES*BYTE_W-1:0] acc_wdata,
  output logic                         rd_valid,
  output logic [HOST_BYTES*BYTE_W-1:0] rd_data,
  input  logic [BANK_W-1:0]            evt_in,
  input  logic                         sci_en,
  output logic                         sci
);
  localparam int unsigned WIN_BYTES = 2 * BANK_W / BYTE_W;
  localparam int unsigned HOST_W    = HOST_BYTES * BYTE_W;

  logic [BANK_W-1:0]           rise;
  logic [BANK_W-1:0]           status_q;
  logic [BANK_W-1:0]           enable_q;
  logic [WIN_BYTES-1:0]        wr_stb;
  logic [WIN_BYTES*BYTE_W-1:0] wr_byte;
  logic [HOST_W-1:0]           rd_word;
  logic [WIN_BYTES*BYTE_W-1:0] reg_view;

  assign reg_view = {enable_q, status_q};

  gpe_edge_detect #(.W(BANK_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .evt_in (evt_in),
    .rise   (rise)
  );

  gpe_byte_lanes #(
    .ADDR_W    (ADDR_W),
    .LANES     (HOST_BYTES),
    .WIN_BYTES (WIN_BYTES),
    .BASE      (BASE_ADDR),
    .SIZE_W    (SIZE_W)
  ) u_lanes (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .reg_view  (reg_view),
    .wr_stb    (wr_stb),
    .wr_byte   (wr_byte),
    .rd_word   (rd_word)
  );

  gpe_reg_bank #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .sci_en   (sci_en),
    .status_q (status_q),
    .enable_q (enable_q),
    .sci      (sci)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      rd_data  <= (acc_valid && !acc_write) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/gpe_event_block_chk.sv
module gpe_event_block_chk #(
  parameter int unsigned BANK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [BANK_W-1:0] evt_in,
  input logic              sci_en,
  input logic              sci,
  input logic              rd_valid,
  input logic [BANK_W-1:0] st,
  input logic [BANK_W-1:0] en
);
  for (genvar g = 0; g < BANK_W; g++) begin : g_bit
    // R3: a rising event line sets its status bit
    p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(evt_in[g]) |=> st[g]);
    // R5: a status bit only drops after a host write
    p_w1c_only_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(st[g]) && !$past(rst)) |-> $past(acc_valid && acc_write));
  end

  // R6: enables hold without a write
  p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_write) |=> $stable(en));

  // R7: read answered in the next cycle
  p_rd_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);

  // R8: interrupt gated by the control enable
  p_sci_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !sci_en |=> !sci);

  // R8: interrupt only with an enabled pending bit
  p_sci_cause_r8: assert property (@(posedge clk) disable iff (rst)
    sci |-> (|(st & en)));
endmodule

bind gpe_event_block gpe_event_block_chk #(.BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .evt_in    (evt_in),
  .sci_en    (sci_en),
  .sci       (sci),
  .rd_valid  (rd_valid),
  .st        (status_q),
  .en        (enable_q)
);

// File: tb/gpe_event_block_tb.sv
`timescale 1ns/1ps
module gpe_event_block_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [15:0] acc_addr;
  logic [2:0]  acc_size;
  logic [31:0] acc_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] evt_in;
  logic        sci_en;
  logic        sci;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpe_event_block u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .evt_in(evt_in),
    .sci_en(sci_en), .sci(sci)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a,
                        input logic [2:0] sz, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    q = rd_data;
    if (!wr) check("R7", "rd_valid", {31'b0, rd_valid}, 32'h1);
  endtask

  task automatic wr(input logic [15:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] q;
    access(1'b1, a, sz, d, q);
  endtask

  task automatic rd_check(input string req, input logic [15:0] a,
                          input logic [2:0] sz, input logic [31:0] exp);
    logic [31:0] q;
    access(1'b0, a, sz, 32'h0, q);
    check(req, "read data", q, exp);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); evt_in[b] = 1'b1;
    @(negedge clk); evt_in[b] = 1'b0;
  endtask

  task automatic t_reset;
    check("R9", "sci after reset", {31'b0, sci}, 32'h0);
    check("R9", "rd_valid after reset", {31'b0, rd_valid}, 32'h0);
    rd_check("R9", 16'hAFE0, 3'd4, 32'h0);
  endtask

  task automatic t_event_status;
    pulse(3);
    rd_check("R3 R4", 16'hAFE0, 3'd2, 32'h0000_0008);
    check("R8", "sci without enable", {31'b0, sci}, 32'h0);
  endtask

  task automatic t_enable_sci;
    wr(16'hAFE2, 3'd1, 32'h0000_0008);
    check("R6 R8", "sci after enable", {31'b0, sci}, 32'h1);
    @(negedge clk); sci_en = 1'b0;
    @(negedge clk);
    check("R8", "sci with control off", {31'b0, sci}, 32'h0);
    sci_en = 1'b1;
    @(negedge clk);
    check("R8", "sci with control on", {31'b0, sci}, 32'h1);
  endtask

  task automatic t_w1c;
    wr(16'hAFE0, 3'd1, 32'h0);
    rd_check("R5", 16'hAFE0, 3'd2, 32'h0000_0008);
    wr(16'hAFE0, 3'd1, 32'h0000_0008);
    check("R5 R8", "sci after clear", {31'b0, sci}, 32'h0);
    rd_check("R5", 16'hAFE0, 3'd2, 32'h0);
    @(negedge clk); evt_in[9] = 1'b1;
    @(negedge clk);
    rd_check("R4", 16'hAFE1, 3'd1, 32'h0000_0002);
    wr(16'hAFE1, 3'd1, 32'h0000_0002);
    repeat (2) @(negedge clk);
    rd_check("R3", 16'hAFE0, 3'd2, 32'h0);
    evt_in[9] = 1'b0;
  endtask

  task automatic t_multibyte;
    wr(16'hAFE0, 3'd4, 32'hA55A_0000);
    rd_check("R2 R6", 16'hAFE0, 3'd4, 32'hA55A_0000);
    rd_check("R2 R4", 16'hAFE3, 3'd1, 32'h0000_00A5);
    rd_check("R7", 16'hAFE1, 3'd2, 32'h0000_5A00);
  endtask

  task automatic t_window;
    wr(16'h1234, 3'd4, 32'hFFFF_FFFF);
    rd_check("R1", 16'hAFE0, 3'd4, 32'hA55A_0000);
    pulse(1);
    check("R8", "sci on enabled bit", {31'b0, sci}, 32'h1);
    rd_check("R1 R2", 16'hAFDE, 3'd4, 32'h0002_0000);
    wr(16'hAFDF, 3'd2, 32'h0000_0211);
    rd_check("R2 R5", 16'hAFE0, 3'd4, 32'hA55A_0000);
    check("R5", "sci after partial clear", {31'b0, sci}, 32'h0);
    wr(16'hAFE3, 3'd2, 32'h0000_FF00);
    rd_check("R1", 16'hAFE2, 3'd4, 32'h0000_005A);
  endtask

  task automatic t_set_wins;
    pulse(6);
    @(negedge clk);
    evt_in[6] = 1'b1;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'hAFE0;
    acc_size = 3'd1; acc_wdata = 32'h0000_0040;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; evt_in[6] = 1'b0;
    rd_check("R5", 16'hAFE0, 3'd2, 32'h0000_0040);
    check("R8", "sci held", {31'b0, sci}, 32'h1);
  endtask

  task automatic t_reset_event;
    @(negedge clk); evt_in[0] = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9", "sci in reset", {31'b0, sci}, 32'h0);
    @(negedge clk); evt_in[0] = 1'b0;
    rd_check("R9", 16'hAFE0, 3'd4, 32'h0000_0001);
    check("R9", "sci after reset event", {31'b0, sci}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    acc_size = '0; acc_wdata = '0; evt_in = '0; sci_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_event_status();
    t_enable_sci();
    t_w1c();
    t_multibyte();
    t_window();
    t_set_wins();
    t_reset_event();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule